// File: doc/BRIEF.md
# Mode-Configurable Watchdog Timer

This block is a watchdog counter for a small processor core. An up-counter advances on each cycle where a prescaler tick enable is high. If software fails to service it, the count rolls over from its all-ones value to zero, and the block then asks for a core reset. Software services the watchdog with a clear strobe, which the clear-watchdog instruction produces. The strobe returns the count to zero.

A two-bit configuration field sets the enable policy. The watchdog can be permanently off, permanently on, on only while the core is awake, or under a software enable bit set at run time. While the policy leaves the watchdog inactive, the counter is held at zero. When the watchdog becomes active again, the count starts from zero.

Each timeout produces a reset request that lasts one cycle. It also sets a status flag that stays set until a power-on reset or a software acknowledge clears it.

Top module: `wdt_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rst_req` and `timeout_flag` are 0. The count starts at zero, so the first timeout needs exactly 2^WIDTH ticks (256 by default).
- R2: The count advances by one only on cycles where `tick_en` is high. The tick that moves the count from all ones to zero is the wrapping tick. `rst_req` goes high in the cycle after the clock edge that takes that tick.
- R3: A `clr_strobe` returns the count to zero. After a clear, a full 2^WIDTH further ticks are needed before the next request.
- R4: When `clr_strobe` is high in the same cycle as the wrapping tick, the clear wins, and neither `rst_req` nor `timeout_flag` is raised.
- R5: With `cfg_mode` = 2'b11, the watchdog is active whatever the values of `core_sleep` and `sw_enable`.
- R6: With `cfg_mode` = 2'b00, the watchdog never raises `rst_req`, however many ticks arrive.
- R7: With `cfg_mode` = 2'b10, the watchdog is active while `core_sleep` is 0 and inactive while `core_sleep` is 1.
- R8: With `cfg_mode` = 2'b01, the watchdog is active exactly when `sw_enable` is 1.
- R9: While the watchdog is inactive, the count is forced to zero. One inactive cycle therefore discards any progress, and a further 2^WIDTH ticks are needed after reactivation.
- R10: `rst_req` is high for exactly one cycle per timeout. `timeout_flag` rises with it and stays high until `status_clr` or `rst` clears it.
- R11: When a timeout and `status_clr` occur in the same cycle, the timeout wins and `timeout_flag` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_mode | input | 2 | Enable policy: 00 off, 01 software bit, 10 awake only, 11 always |
| tick_en | input | 1 | Prescaler tick; the count advances only when high |
| clr_strobe | input | 1 | Clear-watchdog strobe, returns the count to zero |
| core_sleep | input | 1 | High while the core is in sleep |
| sw_enable | input | 1 | Run-time software enable, used only in mode 01 |
| status_clr | input | 1 | Software acknowledge that clears the timeout flag |
| rst_req | output | 1 | One-cycle core reset request on timeout |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
The bench puts the clear strobe on the exact wrapping tick. A design that let the rollover win there would reset a core that had serviced the watchdog in time.

It makes the watchdog inactive for a single cycle partway through a count and then reactivates it. A counter that only froze while inactive, instead of returning to zero, would time out early.

It sleeps the core in the awake-only mode, toggles the software bit in the software mode, and holds the always-on mode while sleeping. A wrong decode of the two-bit field would either miss a timeout or raise one that should not happen.

It also sends an acknowledge in the same cycle as a timeout, and spaces the ticks apart. A flag that lost the set, or a counter that advanced on every clock, would show up in the per-cycle comparison.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Enable policy encodings of the configuration field
    typedef enum logic [1:0] {
        WD_OFF    = 2'b00,
        WD_SWCTL  = 2'b01,
        WD_AWAKE  = 2'b10,
        WD_ALWAYS = 2'b11
    } wd_policy_e;

    // Inputs that the policy decision looks at
    typedef struct packed {
        wd_policy_e policy;
        logic       sleeping;
        logic       sw_on;
    } wd_gate_in_t;

    // Per-cycle counter event
    typedef struct packed {
        logic active;
        logic wrap;
    } wd_event_t;

    function automatic logic policy_active(input wd_gate_in_t g);
        logic a;
        case (g.policy)
            WD_OFF:    a = 1'b0;
            WD_SWCTL:  a = g.sw_on;
            WD_AWAKE:  a = ~g.sleeping;
            WD_ALWAYS: a = 1'b1;
            default:   a = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wdt_gate.sv
module wdt_gate
    import wdt_pkg::*;
(
    input  wd_gate_in_t gate_in,
    output logic        active
);

    always_comb begin
        active = policy_active(gate_in);
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      tick,
    input  logic      clr,
    output wd_event_t evt
);

    localparam logic [WIDTH-1:0] CNT_MAX  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    always_comb begin
        cnt_d      = cnt_q;
        evt.active = active;
        evt.wrap   = 1'b0;
        if (!active) begin
            cnt_d = CNT_ZERO;
        end else if (clr) begin
            cnt_d = CNT_ZERO;
        end else if (tick) begin
            cnt_d    = cnt_q + 1'b1;
            evt.wrap = (cnt_q == CNT_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9
    inactive_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == CNT_ZERO));

    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !clr) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !tick && !clr) |=> $stable(cnt_q));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == CNT_ZERO));

endmodule

// File: rtl/wdt_report.sv
module wdt_report
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wd_event_t evt,
    input  logic      ack,
    output logic      req,
    output logic      flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            flag <= 1'b0;
        end else begin
            req <= evt.wrap;
            if (evt.wrap) begin
                flag <= 1'b1;
            end else if (ack) begin
                flag <= 1'b0;
            end
        end
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);

    // R11
    set_over_ack_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> flag);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic       tick_en,
    input  logic       clr_strobe,
    input  logic       core_sleep,
    input  logic       sw_enable,
    input  logic       status_clr,
    output logic       rst_req,
    output logic       timeout_flag
);

    wd_gate_in_t gate_in;
    logic        wd_active;
    wd_event_t   wd_evt;

    always_comb begin
        gate_in.policy   = wd_policy_e'(cfg_mode);
        gate_in.sleeping = core_sleep;
        gate_in.sw_on    = sw_enable;
    end

    wdt_gate u_gate (
        .gate_in (gate_in),
        .active  (wd_active)
    );

    wdt_count #(.WIDTH(WIDTH)) u_count (
        .clk    (clk),
        .rst    (rst),
        .active (wd_active),
        .tick   (tick_en),
        .clr    (clr_strobe),
        .evt    (wd_evt)
    );

    wdt_report u_report (
        .clk  (clk),
        .rst  (rst),
        .evt  (wd_evt),
        .ack  (status_clr),
        .req  (rst_req),
        .flag (timeout_flag)
    );

    // R6
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |=> !rst_req);

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_strobe |=> !rst_req);

    // R7
    asleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10 && core_sleep) |=> !rst_req);

    // R8
    sw_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 && !sw_enable) |=> !rst_req);

endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;

    localparam int W    = 8;
    localparam int SPAN = 1 << W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic       tick_en = 1'b0;
    logic       clr_strobe = 1'b0;
    logic       core_sleep = 1'b0;
    logic       sw_enable = 1'b0;
    logic       status_clr = 1'b0;
    logic       rst_req;
    logic       timeout_flag;

    always #5 clk = ~clk;

    wdt_core #(.WIDTH(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_mode     (cfg_mode),
        .tick_en      (tick_en),
        .clr_strobe   (clr_strobe),
        .core_sleep   (core_sleep),
        .sw_enable    (sw_enable),
        .status_clr   (status_clr),
        .rst_req      (rst_req),
        .timeout_flag (timeout_flag)
    );

    typedef struct {
        logic  req;
        logic  flag;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   m_cnt = 0;
    logic m_flag = 1'b0;
    bit   done = 1'b0;

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input logic r, input logic [1:0] md, input logic tk,
                        input logic cl, input logic sl, input logic sw,
                        input logic sc, input string tag);
        logic act;
        logic wrap;
        exp_t e;
        @(negedge clk);
        rst = r; cfg_mode = md; tick_en = tk; clr_strobe = cl;
        core_sleep = sl; sw_enable = sw; status_clr = sc;
        case (md)
            2'b00: act = 1'b0;
            2'b01: act = sw;
            2'b10: act = !sl;
            default: act = 1'b1;
        endcase
        wrap = !r && act && tk && !cl && (m_cnt == SPAN - 1);
        if (r || !act || cl) m_cnt = 0;
        else if (tk) m_cnt = (m_cnt + 1) % SPAN;
        if (r) m_flag = 1'b0;
        else if (wrap) m_flag = 1'b1;
        else if (sc) m_flag = 1'b0;
        e.req = wrap; e.flag = m_flag; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic run(input int n, input logic [1:0] md, input logic tk,
                       input logic sl, input logic sw, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, md, tk, 1'b0, sl, sw, 1'b0, tag);
    endtask

    // Monitor: compares the design against the queued expectations
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (rst_req !== e.req || timeout_flag !== e.flag) begin
                n_bad++;
                $display("FAIL %s: rst_req=%0b timeout_flag=%0b expected rst_req=%0b timeout_flag=%0b",
                         e.tag, rst_req, timeout_flag, e.req, e.flag);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R2 R5: always-on while sleeping, wrap after a full span
        run(SPAN, 2'b11, 1'b1, 1'b1, 1'b0, "R5");
        // R10: single-cycle request, sticky flag
        run(4, 2'b11, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        run(2, 2'b11, 1'b0, 1'b0, 1'b0, "R10");
        // R2: spaced ticks
        for (int i = 0; i < SPAN + 2; i++) begin
            step(1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
            step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        end
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R3: clear partway, then a full span is needed
        run(100, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        run(SPAN - 1, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
        run(3, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R4: clear on the wrapping tick
        step(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run(SPAN - 1, 2'b11, 1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run(3, 2'b11, 1'b0, 1'b0, 1'b0, "R4");
        // R6: off mode never requests
        run(3 * SPAN, 2'b00, 1'b1, 1'b0, 1'b1, "R6");
        // R7: awake-only mode
        run(2 * SPAN, 2'b10, 1'b1, 1'b1, 1'b0, "R7");
        run(SPAN + 2, 2'b10, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R9: one inactive cycle discards progress
        run(200, 2'b10, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        run(SPAN - 1, 2'b10, 1'b1, 1'b0, 1'b0, "R9");
        run(2, 2'b10, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R8: software-controlled mode
        run(2 * SPAN, 2'b01, 1'b1, 1'b0, 1'b0, "R8");
        run(SPAN + 1, 2'b01, 1'b1, 1'b0, 1'b1, "R8");
        run(2, 2'b01, 1'b0, 1'b0, 1'b1, "R8");
        // R11: acknowledge coincides with a timeout
        step(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R11");
        run(SPAN - 1, 2'b01, 1'b1, 1'b0, 1'b1, "R11");
        step(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        run(3, 2'b01, 1'b0, 1'b0, 1'b1, "R11");
        // R1: reset clears the sticky flag
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        run(2, 2'b11, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule